// File: doc/BRIEF.md
# Output DC Offset Persistence Window

This block judges, for each audio output channel, whether a DC offset held for the whole of a test window. The window is opened and closed by control-bus events rather than by a timer. Each channel provides two inputs: the digital output of an external offset comparator, which is high while the output sits beyond the offset limit, and a short-circuit protection flag. A channel is flagged only if its comparator stayed high and its protection stayed quiet at every sample in the window.

Software starts a test by writing the offset-enable control bit as 1. Every later read of the diagnostic bytes closes the current window, latches its verdict into that channel's offset bit, and opens the next window at once. Writing the enable bit as 0 stops testing, and from then on the offset bits read as zero.

A small state machine has two states. In `ST_CLOSED` no window runs. In `ST_OPEN` a window is accumulating. There are three transitions:
- `T_ARM`: from `ST_CLOSED` to `ST_OPEN` on an enable write of 1.
- `T_DISARM`: from `ST_OPEN` to `ST_CLOSED` on an enable write of 0.
- `T_REARM`: from `ST_OPEN` back to `ST_OPEN`, which restarts the window, on a read or on an enable write of 1.

Top module: `dc_ofs_window`

## Requirements
- R1: After reset, `win_open` is 0 and every bit of `ofs_flag` is 0.
- R2: A cycle with `ofs_en_wr`=1 and `ofs_en_val`=1 makes `win_open` 1 from the next cycle on. It starts a fresh window whose first sample is taken at the following rising edge. This holds even if a window was already open.
- R3: A cycle with `rd_stb`=1 while `win_open`=1 ends the window. That cycle's inputs are the window's last sample, and the verdict appears on `ofs_flag` in the next cycle. The next window's first sample is taken at the following edge.
- R4: `ofs_flag[i]` (bit i is channel i) is set by a read only if `cmp_hi[i]` was 1 at every sample of the window. A single low sample gives 0.
- R5: If `scp_act[i]` is 1 at any sample of the window, the read gives `ofs_flag[i]`=0, whatever the comparator showed.
- R6: Each channel's verdict depends only on that channel's own inputs.
- R7: A cycle with `ofs_en_wr`=1 and `ofs_en_val`=0 makes `win_open` 0 and clears `ofs_flag` in the next cycle. While the window is closed, `ofs_flag` stays 0, and reads return 0.
- R8: `ofs_flag` does not change in any cycle after which neither `rd_stb` nor `ofs_en_wr` was 1.
- R9: When a read and an enable write fall in the same cycle, the outcome depends on the written value. A write of 0 wins: the window closes and the flags are cleared. A write of 1 lets the read capture the verdict of the open window, and a new window starts. If the window was closed, the new window starts and the flags stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ofs_en_wr | input | 1 | One-cycle strobe: the control byte carrying the offset-enable bit is being written |
| ofs_en_val | input | 1 | Value of the offset-enable bit written with `ofs_en_wr` |
| rd_stb | input | 1 | One-cycle strobe: a diagnostic read operation is taking place |
| cmp_hi | input | NUM_CH | Per-channel offset comparator output, 1 = offset beyond the limit |
| scp_act | input | NUM_CH | Per-channel short-circuit protection active |
| win_open | output | 1 | A test window is running (state `ST_OPEN`) |
| ofs_flag | output | NUM_CH | Latched per-channel offset verdict, bit i = channel i |

## Verification
The bench sweeps every comparator and protection pattern over windows of one to four samples, on both channels in turn. It chains each window off the previous read, so an off-by-one in where a window starts or ends shows up as a wrong verdict. A design that dropped the sample taken in the read cycle, or that carried a low sample across a read, would report persistence wrongly in some of those patterns. The same goes for a design that ignored protection events or let one channel leak into the other. Targeted sequences also cover the following:
- a restart by a second enable write, which a design without re-arming would turn into a missed flag;
- reads while the window is closed, which would expose stale verdicts;
- both orderings of a read coinciding with an enable write, where the wrong priority leaves flags set after disable.

// File: rtl/dc_ofs_pkg.sv
package dc_ofs_pkg;

    typedef enum logic [0:0] {
        ST_CLOSED = 1'b0,
        ST_OPEN   = 1'b1
    } win_state_t;

    typedef struct packed {
        logic start;    // clear per-channel history, next sample is first of window
        logic capture;  // latch verdict from history plus current sample
        logic clear;    // force verdicts to zero
    } win_ctl_t;

endpackage

// File: rtl/dc_ofs_win_ctrl.sv
module dc_ofs_win_ctrl
    import dc_ofs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ofs_en_wr,
    input  logic       ofs_en_val,
    input  logic       rd_stb,
    output win_state_t state,
    output win_ctl_t   ctl
);

    win_state_t state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_CLOSED;
        end else begin
            state <= state_nx;
        end
    end

    // next state and control pulses
    always_comb begin
        state_nx    = state;
        ctl.start   = 1'b0;
        ctl.capture = 1'b0;
        ctl.clear   = 1'b0;
        unique case (state)
            ST_CLOSED: begin
                if (ofs_en_wr && ofs_en_val) begin
                    // T_ARM
                    state_nx  = ST_OPEN;
                    ctl.start = 1'b1;
                end
                if (rd_stb) begin
                    ctl.clear = 1'b1;
                end
            end
            ST_OPEN: begin
                if (ofs_en_wr && !ofs_en_val) begin
                    // T_DISARM: disable wins over a coincident read
                    state_nx  = ST_CLOSED;
                    ctl.clear = 1'b1;
                end else begin
                    if (rd_stb) begin
                        ctl.capture = 1'b1;
                    end
                    if (rd_stb || ofs_en_wr) begin
                        // T_REARM
                        ctl.start = 1'b1;
                    end
                end
            end
            default: begin
                state_nx  = ST_CLOSED;
                ctl.clear = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dc_ofs_chan.sv
module dc_ofs_chan
    import dc_ofs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  win_state_t state,
    input  win_ctl_t   ctl,
    input  logic       cmp_hi,
    input  logic       scp_act,
    output logic       flag
);

    logic seen_clr;
    logic smp_bad;

    assign smp_bad = !cmp_hi || scp_act;

    // history: any sample of the running window that broke persistence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_clr <= 1'b0;
        end else if (ctl.start) begin
            seen_clr <= 1'b0;
        end else if (state == ST_OPEN) begin
            seen_clr <= seen_clr | smp_bad;
        end
    end

    // verdict register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (ctl.clear) begin
            flag <= 1'b0;
        end else if (ctl.capture) begin
            flag <= !(seen_clr || smp_bad);
        end
    end

endmodule

// File: rtl/dc_ofs_window.sv
module dc_ofs_window
    import dc_ofs_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ofs_en_wr,
    input  logic              ofs_en_val,
    input  logic              rd_stb,
    input  logic [NUM_CH-1:0] cmp_hi,
    input  logic [NUM_CH-1:0] scp_act,
    output logic              win_open,
    output logic [NUM_CH-1:0] ofs_flag
);

    win_state_t state;
    win_ctl_t   ctl;

    dc_ofs_win_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ofs_en_wr  (ofs_en_wr),
        .ofs_en_val (ofs_en_val),
        .rd_stb     (rd_stb),
        .state      (state),
        .ctl        (ctl)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dc_ofs_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .state   (state),
            .ctl     (ctl),
            .cmp_hi  (cmp_hi[g]),
            .scp_act (scp_act[g]),
            .flag    (ofs_flag[g])
        );
    end

    assign win_open = (state == ST_OPEN);

endmodule

// File: rtl/dc_ofs_window_chk.sv
module dc_ofs_window_chk #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ofs_en_wr,
    input logic              ofs_en_val,
    input logic              rd_stb,
    input logic [NUM_CH-1:0] cmp_hi,
    input logic [NUM_CH-1:0] scp_act,
    input logic              win_open,
    input logic [NUM_CH-1:0] ofs_flag
);

    logic keep_open;
    assign keep_open = win_open && !(ofs_en_wr && !ofs_en_val);

    AST_ARM_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_en_wr && ofs_en_val) |=> win_open); // R2

    AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_en_wr && !ofs_en_val) |=> (!win_open && ofs_flag == '0)); // R7

    AST_CLOSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |-> (ofs_flag == '0)); // R7

    AST_LOW_SAMPLE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && keep_open) |=> ((ofs_flag & ~$past(cmp_hi)) == '0)); // R4

    AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && keep_open) |=> ((ofs_flag & $past(scp_act)) == '0)); // R5

    AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb && !ofs_en_wr) |=> $stable(ofs_flag)); // R8

    AST_READ_KEEPS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && keep_open) |=> win_open); // R3

endmodule

bind dc_ofs_window dc_ofs_window_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ofs_en_wr  (ofs_en_wr),
    .ofs_en_val (ofs_en_val),
    .rd_stb     (rd_stb),
    .cmp_hi     (cmp_hi),
    .scp_act    (scp_act),
    .win_open   (win_open),
    .ofs_flag   (ofs_flag)
);

// File: tb/sim_dc_ofs_window.sv
module sim_dc_ofs_window;

    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ofs_en_wr = 1'b0;
    logic           ofs_en_val = 1'b0;
    logic           rd_stb = 1'b0;
    logic [NCH-1:0] cmp_hi = '0;
    logic [NCH-1:0] scp_act = '0;
    logic           win_open;
    logic [NCH-1:0] ofs_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dc_ofs_window #(.NUM_CH(NCH)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ofs_en_wr  (ofs_en_wr),
        .ofs_en_val (ofs_en_val),
        .rd_stb     (rd_stb),
        .cmp_hi     (cmp_hi),
        .scp_act    (scp_act),
        .win_open   (win_open),
        .ofs_flag   (ofs_flag)
    );

    task automatic check(input string req, input logic [NCH:0] act, input logic [NCH:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // inputs applied at a falling edge, returns at the next falling edge
    task automatic step(input logic [NCH-1:0] c, input logic [NCH-1:0] s,
                        input logic rd, input logic wr, input logic val);
        cmp_hi     = c;
        scp_act    = s;
        rd_stb     = rd;
        ofs_en_wr  = wr;
        ofs_en_val = val;
        @(negedge clk);
        rd_stb    = 1'b0;
        ofs_en_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [NCH-1:0] prev;
        repeat (3) @(negedge clk);
        check("R1 reset", {win_open, ofs_flag}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: read while closed returns zero
        step(2'b11, 2'b00, 1'b1, 1'b0, 1'b0);
        check("R7 read closed", {win_open, ofs_flag}, 3'b000);

        // R2: arm
        step(2'b00, 2'b00, 1'b0, 1'b1, 1'b1);
        check("R2 arm", {win_open, ofs_flag}, 3'b100);

        // R3 R4 R5 R6: exhaustive sweep, windows chained by reads
        prev = '0;
        for (int len = 1; len <= 4; len++) begin
            for (int pat = 0; pat < (1 << len); pat++) begin
                for (int mode = 0; mode < 2; mode++) begin
                    logic full;
                    logic none;
                    logic [NCH-1:0] exp;
                    full = (pat == (1 << len) - 1);
                    none = (pat == 0);
                    for (int j = 0; j < len; j++) begin
                        logic b;
                        b = pat[j];
                        if (mode == 0) step({1'b1, b}, {b, 1'b0}, j == len - 1, 1'b0, 1'b0);
                        else           step({b, 1'b1}, {1'b0, b}, j == len - 1, 1'b0, 1'b0);
                        if (j < len - 1) check("R8 hold mid-window", {win_open, ofs_flag}, {1'b1, prev});
                    end
                    exp = (mode == 0) ? {none, full} : {full, none};
                    check("R3 R4 R5 R6 sweep", {win_open, ofs_flag}, {1'b1, exp});
                    prev = exp;
                end
            end
        end

        // R2: re-arm restarts window, dropping an earlier low sample
        step(2'b00, 2'b00, 1'b1, 1'b0, 1'b0);
        check("R3 read low", {win_open, ofs_flag}, 3'b100);
        step(2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
        step(2'b11, 2'b00, 1'b0, 1'b1, 1'b1);
        step(2'b11, 2'b00, 1'b1, 1'b0, 1'b0);
        check("R2 rearm restart", {win_open, ofs_flag}, 3'b111);

        // R9: read with enable write of 1 captures, then new window
        step(2'b11, 2'b00, 1'b0, 1'b0, 1'b0);
        step(2'b01, 2'b00, 1'b1, 1'b1, 1'b1);
        check("R9 read+arm capture", {win_open, ofs_flag}, 3'b101);
        step(2'b11, 2'b00, 1'b1, 1'b0, 1'b0);
        check("R9 new window after read+arm", {win_open, ofs_flag}, 3'b111);

        // R9: read with enable write of 0, disable wins
        step(2'b11, 2'b00, 1'b1, 1'b1, 1'b0);
        check("R9 read+disarm", {win_open, ofs_flag}, 3'b000);

        // R7: closed stays zero with persistent offset and reads
        step(2'b11, 2'b00, 1'b0, 1'b0, 1'b0);
        step(2'b11, 2'b00, 1'b1, 1'b0, 1'b0);
        check("R7 closed read", {win_open, ofs_flag}, 3'b000);

        // R9: read+arm while closed gives zero and opens
        step(2'b11, 2'b00, 1'b1, 1'b1, 1'b1);
        check("R9 closed read+arm", {win_open, ofs_flag}, 3'b100);
        step(2'b11, 2'b00, 1'b1, 1'b0, 1'b0);
        check("R4 one-sample window", {win_open, ofs_flag}, 3'b111);

        // R7: disarm clears latched flags
        step(2'b11, 2'b00, 1'b0, 1'b1, 1'b0);
        check("R7 disarm clears", {win_open, ofs_flag}, 3'b000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule